// File: doc/BRIEF.md
# Bit-serial 16-bit ALU with a single flag

This block is a one-bit arithmetic and logic unit that works on 16-bit words one bit per clock, least significant bit first. An instruction sequencer starts an operation with a one-cycle `start` pulse and an operation code. It then presents the operand bits on `a_bit` and `b_bit`, each one marked by `bit_vld`. Gaps between bits are allowed. The result comes back serially on `res_bit`, qualified by `res_vld`. A `done` pulse marks the final result bit and the settled flag.

There is a single state bit, `flag`, and the operation class decides how it is used:
- **Carry/borrow class** (add, subtract, increment, decrement, shifts, rotates): the flag is the running carry or borrow, or the bit shifted out.
- **Zero class** (negate, complement, logic): the flag is preset to 1 and cleared by the first result bit that is 1.

Right shifts cannot emit result bit k until operand bit k+1 has arrived. For these the block delays the stream by one bit and adds one tail cycle after the last operand bit.

Top module: `sbalu_core`

## Requirements
- R1: After a `start` pulse in idle, each `bit_vld` cycle consumes one operand bit, LSB first. Exactly 16 result bits are returned on `res_vld`, LSB first. `done` is high together with the 16th result bit.
- R2: The operation code `op[3:0]` is encoded as follows: 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 increment, 5 decrement, 6 negate, 7 complement, 8 AND, 9 OR, 10 XOR, 11 shift left, 12 rotate left through flag, 13 logical shift right, 14 arithmetic shift right, 15 rotate right through flag.
- R3: Add and subtract produce the 16-bit sum `a+b` and difference `a-b`, and the flag ends as the carry out or borrow out. The plain forms start with carry/borrow 0. The with-carry forms use the flag as it stood at `start`.
- R4: Increment gives `a+1`, with flag 1 only when `a` was 0xFFFF. Decrement gives `a-1`, with flag 1 only when `a` was 0.
- R5: Negate gives the two's complement of `a` and complement gives `~a`. For both, the final flag is 1 exactly when the result is zero. The flag reads 1 in the cycle after `start`.
- R6: AND, OR and XOR of `a` and `b` end with flag 1 exactly when the result is zero.
- R7: Shift left gives `a<<1` and rotate left gives `{a[14:0], old flag}`. Both end with the flag equal to `a[15]`.
- R8: Logical shift right gives `a>>1`, arithmetic shift right gives `{a[15], a[15:1]}`, and rotate right gives `{old flag, a[15:1]}`. All three end with the flag equal to `a[0]`. Their final result bit and `done` come one cycle later than for the other operations.
- R9: A `start` pulse while busy has no effect on the running operation. `bit_vld` while idle produces no result bits and leaves the flag unchanged.
- R10: After reset, `flag`, `busy`, `res_vld` and `done` are all 0. `done` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (honoured when idle) |
| op | input | 4 | Operation code, latched at start |
| bit_vld | input | 1 | Operand bits on a_bit/b_bit are valid this cycle |
| a_bit | input | 1 | First operand serial bit |
| b_bit | input | 1 | Second operand serial bit |
| res_bit | output | 1 | Result serial bit |
| res_vld | output | 1 | res_bit is valid |
| done | output | 1 | Last result bit and final flag this cycle |
| busy | output | 1 | Operation in progress |
| flag | output | 1 | The single carry/borrow/zero flag |

## Verification
Every operation code is driven with random operands and compared against a whole-word model. This separates bit-ordering and carry-chain faults from faults in flag meaning. Directed values then hit the edges of each class:
- all-ones plus one, and zero minus one, expose carry and borrow propagation across all 16 bits;
- negate of 0 and of 0x8000 separates the first-one detection from the zero flag;
- 0x8000 and 0x0001 under the right shifts tell sign keep, flag rotation and the tail cycle apart.

Runs with idle gaps between operand bits, a stray `start` inside an operation, and strobes while idle check that only qualified bits advance the state.

// File: rtl/sbalu_pkg.sv
package sbalu_pkg;

  localparam int unsigned OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBC = 4'd3,
    OP_INC = 4'd4,
    OP_DEC = 4'd5,
    OP_NEG = 4'd6,
    OP_COM = 4'd7,
    OP_AND = 4'd8,
    OP_OR  = 4'd9,
    OP_XOR = 4'd10,
    OP_LSL = 4'd11,
    OP_ROL = 4'd12,
    OP_LSR = 4'd13,
    OP_ASR = 4'd14,
    OP_ROR = 4'd15
  } sbalu_op_e;

  typedef struct packed {
    logic is_right;  // result lags operand by one bit, tail cycle
    logic is_left;   // result taken from delayed operand bit
    logic is_zero;   // flag is a zero indicator
  } sbalu_cls_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_TAIL = 2'd2
  } sbalu_state_e;

  // one full-adder step: {carry_out, sum}
  function automatic logic [1:0] add_step(logic a, logic b, logic c);
    logic s;
    logic co;
    s  = a ^ b ^ c;
    co = (a & b) | (c & (a ^ b));
    return {co, s};
  endfunction

  // one full-subtractor step: {borrow_out, difference}
  function automatic logic [1:0] sub_step(logic a, logic b, logic br);
    logic d;
    logic bo;
    d  = a ^ b ^ br;
    bo = (~a & b) | (~(a ^ b) & br);
    return {bo, d};
  endfunction

  // flag value loaded when an operation starts
  function automatic logic flag_preset(sbalu_op_e op, logic cur);
    case (op)
      OP_ADD, OP_SUB:                          return 1'b0;
      OP_INC, OP_DEC:                          return 1'b1;
      OP_NEG, OP_COM, OP_AND, OP_OR, OP_XOR:   return 1'b1;
      default:                                 return cur;
    endcase
  endfunction

  function automatic logic is_zero_op(sbalu_op_e op);
    return (op == OP_NEG) || (op == OP_COM) || (op == OP_AND) ||
           (op == OP_OR)  || (op == OP_XOR);
  endfunction

endpackage

// File: rtl/sbalu_bit_counter.sv
module sbalu_bit_counter #(
  parameter int unsigned WIDTH = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  output logic first,
  output logic last
);
  localparam int unsigned IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WIDTH - 1);

  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (clear) begin
      idx_q <= '0;
    end else if (step) begin
      idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
    end
  end

  assign first = (idx_q == '0);
  assign last  = (idx_q == LAST_IDX);
endmodule

// File: rtl/sbalu_op_decode.sv
module sbalu_op_decode
  import sbalu_pkg::*;
(
  input  sbalu_op_e  op,
  output sbalu_cls_t cls
);
  always_comb begin
    cls = '0;
    case (op)
      OP_LSR, OP_ASR, OP_ROR: cls.is_right = 1'b1;
      OP_LSL, OP_ROL:         cls.is_left  = 1'b1;
      default:                cls.is_zero  = is_zero_op(op);
    endcase
  end
endmodule

// File: rtl/sbalu_bit_engine.sv
module sbalu_bit_engine
  import sbalu_pkg::*;
(
  input  sbalu_op_e  op,
  input  sbalu_cls_t cls,
  input  logic       a_bit,
  input  logic       b_bit,
  input  logic       flag,
  input  logic       dly,
  input  logic       low,
  input  logic       first,
  input  logic       last,
  input  logic       tail,
  output logic       res,
  output logic       emit,
  output logic       flag_nxt,
  output logic       dly_nxt
);
  logic [1:0] step_v;

  always_comb begin
    res      = 1'b0;
    emit     = 1'b1;
    flag_nxt = flag;
    dly_nxt  = a_bit;
    step_v   = 2'b00;
    if (tail) begin
      // top result bit of a right shift
      dly_nxt  = dly;
      flag_nxt = low;
      case (op)
        OP_ASR:  res = dly;
        OP_ROR:  res = flag;
        default: res = 1'b0;
      endcase
    end else if (cls.is_right) begin
      res  = a_bit;        // stands for result bit idx-1
      emit = !first;
    end else if (cls.is_left) begin
      res      = dly;
      flag_nxt = last ? a_bit : flag;
    end else if (cls.is_zero) begin
      case (op)
        OP_NEG:  res = a_bit ^ ~flag;  // copy until first one, then invert
        OP_COM:  res = ~a_bit;
        OP_AND:  res = a_bit & b_bit;
        OP_OR:   res = a_bit | b_bit;
        default: res = a_bit ^ b_bit;
      endcase
      flag_nxt = flag & ~res;
    end else begin
      case (op)
        OP_ADD, OP_ADC: step_v = add_step(a_bit, b_bit, flag);
        OP_SUB, OP_SBC: step_v = sub_step(a_bit, b_bit, flag);
        OP_INC:         step_v = add_step(a_bit, 1'b0, flag);
        default:        step_v = sub_step(a_bit, 1'b0, flag);
      endcase
      res      = step_v[0];
      flag_nxt = step_v[1];
    end
  end
endmodule

// File: rtl/sbalu_core.sv
module sbalu_core
  import sbalu_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [3:0] op,
  input  logic       bit_vld,
  input  logic       a_bit,
  input  logic       b_bit,
  output logic       res_bit,
  output logic       res_vld,
  output logic       done,
  output logic       busy,
  output logic       flag
);
  sbalu_state_e st_q;
  sbalu_op_e    op_q;
  sbalu_op_e    op_in;
  sbalu_cls_t   cls;
  logic flag_q, dly_q, low_q;
  logic res_q, vld_q, done_q;
  logic first, last;
  logic eng_res, eng_emit, eng_flag, eng_dly;

  // named events
  logic op_start, bit_take, tail_go, in_tail;

  assign op_in    = sbalu_op_e'(op);
  assign op_start = start && (st_q == ST_IDLE);
  assign bit_take = bit_vld && (st_q == ST_RUN);
  assign in_tail  = (st_q == ST_TAIL);
  assign tail_go  = in_tail;

  sbalu_bit_counter #(.WIDTH(WIDTH)) cnt_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (op_start),
    .step  (bit_take),
    .first (first),
    .last  (last)
  );

  sbalu_op_decode dec_i (
    .op  (op_q),
    .cls (cls)
  );

  sbalu_bit_engine eng_i (
    .op       (op_q),
    .cls      (cls),
    .a_bit    (a_bit),
    .b_bit    (b_bit),
    .flag     (flag_q),
    .dly      (dly_q),
    .low      (low_q),
    .first    (first),
    .last     (last),
    .tail     (in_tail),
    .res      (eng_res),
    .emit     (eng_emit),
    .flag_nxt (eng_flag),
    .dly_nxt  (eng_dly)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      op_q   <= OP_ADD;
      flag_q <= 1'b0;
      dly_q  <= 1'b0;
      low_q  <= 1'b0;
      res_q  <= 1'b0;
      vld_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      vld_q  <= 1'b0;
      done_q <= 1'b0;
      if (op_start) begin
        op_q   <= op_in;
        flag_q <= flag_preset(op_in, flag_q);
        dly_q  <= (op_in == OP_ROL) ? flag_q : 1'b0;
        st_q   <= ST_RUN;
      end else if (bit_take) begin
        flag_q <= eng_flag;
        dly_q  <= eng_dly;
        if (first) low_q <= a_bit;
        res_q  <= eng_res;
        vld_q  <= eng_emit;
        if (last) begin
          st_q   <= cls.is_right ? ST_TAIL : ST_IDLE;
          done_q <= !cls.is_right;
        end
      end else if (tail_go) begin
        flag_q <= eng_flag;
        dly_q  <= eng_dly;
        res_q  <= eng_res;
        vld_q  <= 1'b1;
        done_q <= 1'b1;
        st_q   <= ST_IDLE;
      end
    end
  end

  assign res_bit = res_q;
  assign res_vld = vld_q;
  assign done    = done_q;
  assign busy    = (st_q != ST_IDLE);
  assign flag    = flag_q;
endmodule

// File: rtl/sbalu_checker.sv
module sbalu_checker
  import sbalu_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic [3:0] op,
  input logic       res_bit,
  input logic       res_vld,
  input logic       done,
  input logic       busy,
  input logic       flag,
  input logic       op_start
);
  localparam int unsigned CW = $clog2(WIDTH + 1) + 1;

  logic [CW-1:0] vld_cnt;
  logic          saw_one;
  logic          zero_kind;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_cnt   <= '0;
      saw_one   <= 1'b0;
      zero_kind <= 1'b0;
    end else if (op_start) begin
      vld_cnt   <= '0;
      saw_one   <= 1'b0;
      zero_kind <= is_zero_op(sbalu_op_e'(op));
    end else if (res_vld) begin
      vld_cnt <= vld_cnt + 1'b1;
      if (res_bit) saw_one <= 1'b1;
    end
  end

  a_r1_done_with_result: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> res_vld);

  a_r1_bit_count: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (vld_cnt == CW'(WIDTH - 1)));

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !res_vld);

  a_r9_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  a_r3_plain_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start && (op == OP_ADD || op == OP_SUB)) |=> !flag);

  a_r5_zero_preset: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start && is_zero_op(sbalu_op_e'(op))) |=> flag);

  a_r6_zero_final: assert property (@(posedge clk) disable iff (!rst_n)
    (done && zero_kind) |-> (flag == !(saw_one || res_bit)));
endmodule

bind sbalu_core sbalu_checker #(.WIDTH(WIDTH)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .op       (op),
  .res_bit  (res_bit),
  .res_vld  (res_vld),
  .done     (done),
  .busy     (busy),
  .flag     (flag),
  .op_start (op_start)
);

// File: tb/sbalu_core_tb.sv
`timescale 1ns/1ps
module sbalu_core_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [3:0] op_i = 4'd0;
  logic bit_vld = 1'b0;
  logic a_bit = 1'b0;
  logic b_bit = 1'b0;
  logic res_bit, res_vld, done, busy, flag;

  int checks = 0;
  int fails = 0;
  logic mflag = 1'b0;

  logic [15:0] got = '0;
  int nvld = 0;
  bit done_seen = 1'b0;
  logic done_flag = 1'b0;

  always #5 clk = ~clk;

  sbalu_core dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op_i),
    .bit_vld(bit_vld), .a_bit(a_bit), .b_bit(b_bit),
    .res_bit(res_bit), .res_vld(res_vld), .done(done),
    .busy(busy), .flag(flag)
  );

  always @(negedge clk) begin
    if (res_vld) begin
      got  = {res_bit, got[15:1]};
      nvld = nvld + 1;
    end
    if (done) begin
      done_seen = 1'b1;
      done_flag = flag;
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // whole-word reference: {flag, result}
  function automatic logic [16:0] model(input logic [3:0] op, input logic [15:0] a,
                                        input logic [15:0] b, input logic fin);
    logic [16:0] w;
    logic [15:0] r;
    case (op)
      4'd0:  w = {1'b0, a} + {1'b0, b};
      4'd1:  w = {1'b0, a} + {1'b0, b} + {16'd0, fin};
      4'd2:  w = {1'b0, a} - {1'b0, b};
      4'd3:  w = {1'b0, a} - {1'b0, b} - {16'd0, fin};
      4'd4:  w = {1'b0, a} + 17'd1;
      4'd5:  w = {(a == 16'd0), a - 16'd1};
      4'd6:  begin r = 16'd0 - a;  w = {(r == 16'd0), r}; end
      4'd7:  begin r = ~a;         w = {(r == 16'd0), r}; end
      4'd8:  begin r = a & b;      w = {(r == 16'd0), r}; end
      4'd9:  begin r = a | b;      w = {(r == 16'd0), r}; end
      4'd10: begin r = a ^ b;      w = {(r == 16'd0), r}; end
      4'd11: w = {a[15], a[14:0], 1'b0};
      4'd12: w = {a[15], a[14:0], fin};
      4'd13: w = {a[0], 1'b0, a[15:1]};
      4'd14: w = {a[0], a[15], a[15:1]};
      default: w = {a[0], fin, a[15:1]};
    endcase
    return w;
  endfunction

  function automatic string tag_of(input logic [3:0] op);
    if (op <= 4'd3) return "R3";
    if (op <= 4'd5) return "R4";
    if (op <= 4'd7) return "R5";
    if (op <= 4'd10) return "R6";
    if (op <= 4'd12) return "R7";
    return "R8";
  endfunction

  task automatic run_op(input logic [3:0] op, input logic [15:0] a,
                        input logic [15:0] b, input bit gap, input bit interfere);
    logic [16:0] exp;
    string tg;
    exp = model(op, a, b, mflag);
    tg  = tag_of(op);
    @(negedge clk);
    nvld = 0; done_seen = 1'b0; got = '0;
    start = 1'b1; op_i = op;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 16; i++) begin
      if (gap && (i % 3 == 1)) begin
        bit_vld = 1'b0; a_bit = 1'($urandom); b_bit = 1'($urandom);
        @(negedge clk);
      end
      if (interfere && i == 5) begin
        start = 1'b1; op_i = ~op;
      end
      bit_vld = 1'b1; a_bit = a[i]; b_bit = b[i];
      @(negedge clk);
      bit_vld = 1'b0; start = 1'b0;
    end
    repeat (3) @(negedge clk);
    #1;
    check(done_seen, "R1", $sformatf("done op=%0d", op), 32'(done_seen), 32'd1);
    check(nvld == 16, "R1", $sformatf("result bit count op=%0d", op), 32'(nvld), 32'd16);
    check(got == exp[15:0], tg, $sformatf("R2 op=%0d a=%h b=%h result", op, a, b),
          32'(got), 32'(exp[15:0]));
    check(done_flag == exp[16], tg, $sformatf("op=%0d a=%h b=%h flag", op, a, b),
          32'(done_flag), 32'(exp[16]));
    mflag = exp[16];
  endtask

  task automatic set_flag(input logic v);
    run_op(v ? 4'd5 : 4'd0, 16'd0, 16'd0, 1'b0, 1'b0);
  endtask

  task automatic test_reset;
    #1;
    check(flag == 1'b0 && busy == 1'b0 && res_vld == 1'b0 && done == 1'b0, "R10",
          "reset outputs", {28'd0, flag, busy, res_vld, done}, 32'd0);
  endtask

  task automatic test_random;
    for (int op = 0; op < 16; op++) begin
      for (int k = 0; k < 6; k++) begin
        if (k == 2) set_flag(1'b1);
        if (k == 4) set_flag(1'b0);
        run_op(4'(op), 16'($urandom), 16'($urandom), (k % 2) == 1, 1'b0);
      end
    end
  endtask

  task automatic test_edges;
    run_op(4'd0, 16'hFFFF, 16'h0001, 1'b0, 1'b0);   // R3 carry through all bits
    run_op(4'd1, 16'hFFFF, 16'h0000, 1'b0, 1'b0);   // R3 carry-in from flag
    run_op(4'd2, 16'h0000, 16'h0001, 1'b0, 1'b0);   // R3 borrow
    run_op(4'd3, 16'h0000, 16'h0000, 1'b1, 1'b0);   // R3 borrow-in from flag
    run_op(4'd4, 16'hFFFF, 16'h0000, 1'b0, 1'b0);   // R4 overflow
    run_op(4'd5, 16'h0000, 16'h0000, 1'b0, 1'b0);   // R4 underflow
    run_op(4'd6, 16'h0000, 16'h1234, 1'b0, 1'b0);   // R5 neg zero
    run_op(4'd6, 16'h8000, 16'h0000, 1'b0, 1'b0);   // R5 neg of min
    run_op(4'd7, 16'hFFFF, 16'h0000, 1'b0, 1'b0);   // R5 com to zero
    run_op(4'd8, 16'hAAAA, 16'h5555, 1'b1, 1'b0);   // R6 and zero
    run_op(4'd14, 16'h8000, 16'h0000, 1'b0, 1'b0);  // R8 sign kept
    run_op(4'd15, 16'h0001, 16'h0000, 1'b0, 1'b0);  // R8 flag <- bit0
    run_op(4'd15, 16'h0000, 16'h0000, 1'b0, 1'b0);  // R8 old flag into bit15
    run_op(4'd12, 16'h8000, 16'h0000, 1'b0, 1'b0);  // R7 flag <- bit15
    run_op(4'd12, 16'h0000, 16'h0000, 1'b1, 1'b0);  // R7 old flag into bit0
    run_op(4'd11, 16'h4001, 16'h0000, 1'b0, 1'b0);  // R7 shift left
  endtask

  task automatic test_ignored;
    logic f0;
    // R9: start while busy must not change the running operation
    run_op(4'd0, 16'h1234, 16'h4321, 1'b0, 1'b1);
    run_op(4'd13, 16'hF00F, 16'h0000, 1'b1, 1'b1);
    // R9: bit strobes while idle produce nothing and keep the flag
    f0 = flag;
    @(negedge clk);
    nvld = 0;
    for (int i = 0; i < 10; i++) begin
      bit_vld = 1'b1; a_bit = 1'($urandom); b_bit = 1'($urandom);
      @(negedge clk);
    end
    bit_vld = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    check(nvld == 0, "R9", "result bits while idle", 32'(nvld), 32'd0);
    check(flag == f0, "R9", "flag after idle strobes", 32'(flag), 32'(f0));
    run_op(4'd1, 16'h00FF, 16'h0F0F, 1'b0, 1'b0);
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_edges();
    test_random();
    test_ignored();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end
endmodule